// File: doc/BRIEF.md
# Timer Trigger-Driven Counter Front End

This block sits in front of a general-purpose timer and decides when its up-counter advances. Two external pins are first brought into the system clock domain and then cleaned by a programmable glitch filter. Each pin then gets a selectable active edge. Four internal trigger lines arrive already synchronous.

A trigger-select code picks one of these sources as the counting trigger. A mode field sets how the counter advances:

- In internal-clock mode it steps on every system clock.
- In external-clock mode it steps once per active edge of the chosen trigger.

A sticky flag records that a trigger edge was seen. Software clears the flag with a one-cycle pulse.

Software sets all control fields directly:

- mode
- trigger select
- channel-2 mapping
- per-pin polarity
- per-pin filter code
- run enable

The counter value and the trigger flag are the block's only outputs.

Top module: `tmr_trig_counter`

## Requirements
- R1: After synchronous reset the count is 0 and the trigger flag is 0.
- R2: With mode 3'b000 and run=1, the count rises by one on every clock edge. With run=0, the count holds in every mode.
- R3: With mode 3'b111 and run=1, the count rises by exactly one per active edge of the selected trigger and holds otherwise.
- R4: Trigger select codes:
  - 3'b0kk: rising edge of internal line itr_in[kk].
  - 3'b100: both edges of filtered pin 1 (polarity not applied).
  - 3'b101: active edge of filtered pin 1.
  - 3'b110: active edge of filtered pin 2.
  - 3'b111: no trigger.
- R5: A pin's polarity bit at 0 makes the rising edge active. At 1 it makes the falling edge active.
- R6: Filter code 0 passes the synchronized level through unchanged. A code N>0 updates the filtered level only after the synchronized input has held a new level for 2*N consecutive clocks. With N=2, a 4-clock pulse passes and a 3-clock pulse is dropped.
- R7: Pin 2 produces triggers only while the channel-2 map field equals 2'b01. Any other value suppresses its edges.
- R8: With filter code 0, a pin edge driven between clock edges shows in the count after the 4th rising clock edge, and not after the 3rd.
- R9: The trigger flag sets on any selected trigger edge in any mode and stays set until a clear pulse. A set in the same cycle as a clear wins.
- R10: The counter wraps from 16'hFFFF to 16'h0000.
- R11: In modes other than 3'b000 and 3'b111 the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Counting mode (000 internal clock, 111 external trigger) |
| cfg_trig_sel | input | 3 | Trigger source select code |
| cfg_ch2_map | input | 2 | Channel-2 input mapping, 01 routes pin 2 |
| cfg_pol1 | input | 1 | Pin 1 active edge, 1 = falling |
| cfg_pol2 | input | 1 | Pin 2 active edge, 1 = falling |
| cfg_filt1 | input | 4 | Pin 1 filter code |
| cfg_filt2 | input | 4 | Pin 2 filter code |
| cfg_run | input | 1 | Counter enable |
| flag_clr | input | 1 | Clear pulse for the trigger flag |
| itr_in | input | 4 | Internal trigger lines |
| pin1 | input | 1 | External input pin 1 (asynchronous) |
| pin2 | input | 1 | External input pin 2 (asynchronous) |
| count | output | 16 | Counter value |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
The bench builds the block with its default parameters: a 16-bit counter and 4-bit filter codes. With these values a full wrap through 16'hFFFF takes 65536 clocks, which fits within a single run. Filter code 2 gives a 4-clock acceptance window, so both the pass length and the one-clock-short drop sit at the boundary. Filter code 0 gives the exact four-edge pin-to-count latency that the bench samples on both sides.

// File: rtl/tmr_trig_pkg.sv
package tmr_trig_pkg;

    localparam int CNT_W   = 16;
    localparam int FILT_W  = 4;
    localparam int ITR_N   = 4;
    localparam int FCNT_W  = FILT_W + 1;

    typedef enum logic [2:0] {
        MODE_INTCLK = 3'b000,
        MODE_EXTCLK = 3'b111
    } cnt_mode_e;

    typedef enum logic [2:0] {
        SRC_PIN1_ANY  = 3'b100,
        SRC_PIN1_FILT = 3'b101,
        SRC_PIN2_FILT = 3'b110,
        SRC_NONE      = 3'b111
    } trig_src_e;

    localparam logic [1:0] CH2_MAP_PIN2 = 2'b01;

    typedef struct packed {
        logic              falling;
        logic [FILT_W-1:0] code;
    } pin_cfg_t;

    typedef struct packed {
        logic active_edge;
        logic any_edge;
    } pin_evt_t;

    function automatic logic [FCNT_W-1:0] filt_limit(input logic [FILT_W-1:0] code);
        return {code, 1'b0};
    endfunction

endpackage

// File: rtl/tmr_pin_conditioner.sv
module tmr_pin_conditioner
    import tmr_trig_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pin,
    input  pin_cfg_t cfg,
    output pin_evt_t evt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_lvl;
    logic                   filt_q;
    logic                   filt_prev_q;
    logic                   pol_lvl;
    logic                   pol_prev;
    logic [FCNT_W-1:0]      run_cnt_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end
    assign sync_lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q    <= 1'b0;
            run_cnt_q <= '0;
        end else if (cfg.code == '0) begin
            filt_q    <= sync_lvl;
            run_cnt_q <= '0;
        end else if (sync_lvl != filt_q) begin
            if (run_cnt_q == filt_limit(cfg.code) - FCNT_W'(1)) begin
                filt_q    <= sync_lvl;
                run_cnt_q <= '0;
            end else begin
                run_cnt_q <= run_cnt_q + FCNT_W'(1);
            end
        end else begin
            run_cnt_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) filt_prev_q <= 1'b0;
        else     filt_prev_q <= filt_q;
    end

    assign pol_lvl  = filt_q ^ cfg.falling;
    assign pol_prev = filt_prev_q ^ cfg.falling;

    assign evt.active_edge = pol_lvl & ~pol_prev;
    assign evt.any_edge    = filt_q ^ filt_prev_q;

    assert_filter_source_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> filt_q == $past(sync_lvl));

    assert_zero_filter_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg.code == '0) |=> filt_q == $past(sync_lvl));

endmodule

// File: rtl/tmr_trig_mux.sv
module tmr_trig_mux
    import tmr_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       sel,
    input  logic [ITR_N-1:0] itr_in,
    input  pin_evt_t         evt1,
    input  pin_evt_t         evt2,
    input  logic             ch2_routed,
    output logic             trig
);
    logic [ITR_N-1:0] itr_prev_q;
    logic [ITR_N-1:0] itr_rise;

    always_ff @(posedge clk) begin
        if (rst) itr_prev_q <= '0;
        else     itr_prev_q <= itr_in;
    end

    generate
        for (genvar k = 0; k < ITR_N; k++) begin : g_itr
            assign itr_rise[k] = itr_in[k] & ~itr_prev_q[k];
        end
    endgenerate

    always_comb begin
        trig = 1'b0;
        if (!sel[2]) begin
            trig = itr_rise[sel[1:0]];
        end else begin
            case (sel)
                SRC_PIN1_ANY:  trig = evt1.any_edge;
                SRC_PIN1_FILT: trig = evt1.active_edge;
                SRC_PIN2_FILT: trig = evt2.active_edge & ch2_routed;
                default:       trig = 1'b0;
            endcase
        end
    end

    assert_none_code_R4: assert property (@(posedge clk) disable iff (rst)
        (sel == SRC_NONE) |-> !trig);

    assert_ch2_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (!ch2_routed && sel == SRC_PIN2_FILT) |-> !trig);

endmodule

// File: rtl/tmr_up_counter.sv
module tmr_up_counter
    import tmr_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       mode,
    input  logic             run,
    input  logic             trig,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    logic step;

    always_comb begin
        step = 1'b0;
        if (run) begin
            case (mode)
                MODE_INTCLK: step = 1'b1;
                MODE_EXTCLK: step = trig;
                default:     step = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (step) count <= count + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)       flag <= 1'b0;
        else if (trig) flag <= 1'b1;
        else if (clr)  flag <= 1'b0;
    end

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> count == $past(count));

    assert_ext_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EXTCLK && run && trig) |=> count == $past(count) + CNT_W'(1));

    assert_ext_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_EXTCLK && !trig) |=> $stable(count));

    assert_other_mode_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_EXTCLK && mode != MODE_INTCLK) |=> $stable(count));

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (rst)
        trig |=> flag);

endmodule

// File: rtl/tmr_trig_counter.sv
module tmr_trig_counter
    import tmr_trig_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cfg_mode,
    input  logic [2:0]        cfg_trig_sel,
    input  logic [1:0]        cfg_ch2_map,
    input  logic              cfg_pol1,
    input  logic              cfg_pol2,
    input  logic [FILT_W-1:0] cfg_filt1,
    input  logic [FILT_W-1:0] cfg_filt2,
    input  logic              cfg_run,
    input  logic              flag_clr,
    input  logic [ITR_N-1:0]  itr_in,
    input  logic              pin1,
    input  logic              pin2,
    output logic [CNT_W-1:0]  count,
    output logic              trig_flag
);
    pin_cfg_t cfg1, cfg2;
    pin_evt_t evt1, evt2;
    logic     trig;

    assign cfg1 = '{falling: cfg_pol1, code: cfg_filt1};
    assign cfg2 = '{falling: cfg_pol2, code: cfg_filt2};

    tmr_pin_conditioner #(.SYNC_STAGES(2)) u_pin1 (
        .clk(clk), .rst(rst), .pin(pin1), .cfg(cfg1), .evt(evt1)
    );

    tmr_pin_conditioner #(.SYNC_STAGES(2)) u_pin2 (
        .clk(clk), .rst(rst), .pin(pin2), .cfg(cfg2), .evt(evt2)
    );

    tmr_trig_mux u_mux (
        .clk(clk), .rst(rst), .sel(cfg_trig_sel), .itr_in(itr_in),
        .evt1(evt1), .evt2(evt2), .ch2_routed(cfg_ch2_map == CH2_MAP_PIN2),
        .trig(trig)
    );

    tmr_up_counter u_cnt (
        .clk(clk), .rst(rst), .mode(cfg_mode), .run(cfg_run), .trig(trig),
        .clr(flag_clr), .count(count), .flag(trig_flag)
    );

endmodule

// File: tb/tmr_trig_counter_tb.sv
module tmr_trig_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  cfg_mode, cfg_trig_sel;
    logic [1:0]  cfg_ch2_map;
    logic        cfg_pol1, cfg_pol2;
    logic [3:0]  cfg_filt1, cfg_filt2;
    logic        cfg_run, flag_clr;
    logic [3:0]  itr_in;
    logic        pin1, pin2;
    logic [15:0] count;
    logic        trig_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [15:0] cnt;
        logic        flg;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    event sample_ev;

    always #4 clk = ~clk;

    tmr_trig_counter dut_i (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_trig_sel(cfg_trig_sel),
        .cfg_ch2_map(cfg_ch2_map), .cfg_pol1(cfg_pol1), .cfg_pol2(cfg_pol2),
        .cfg_filt1(cfg_filt1), .cfg_filt2(cfg_filt2), .cfg_run(cfg_run),
        .flag_clr(flag_clr), .itr_in(itr_in), .pin1(pin1), .pin2(pin2),
        .count(count), .trig_flag(trig_flag)
    );

    // monitor: compares design outputs with the expected item
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (count !== e.cnt || trig_flag !== e.flg) begin
                    n_fail++;
                    $display("FAIL %s: count=%h flag=%b expected count=%h flag=%b",
                             e.tag, count, trig_flag, e.cnt, e.flg);
                end
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [15:0] c, input logic f, input string tag);
        exp_t e;
        e.cnt = c; e.flg = f; e.tag = tag;
        exp_q.push_back(e);
        -> sample_ev;
        wait (exp_q.size() == 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run hung, actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        cfg_mode = 3'b000; cfg_trig_sel = 3'b111; cfg_ch2_map = 2'b00;
        cfg_pol1 = 0; cfg_pol2 = 0; cfg_filt1 = 0; cfg_filt2 = 0;
        cfg_run = 0; flag_clr = 0; itr_in = 0; pin1 = 0; pin2 = 0;
        cyc(1);
        do_reset();
        expect_out(16'd0, 1'b0, "R1 reset state");

        // R2 internal clock counting and run gate
        cfg_run = 1'b1; cyc(10);
        expect_out(16'd10, 1'b0, "R2 internal count");
        cfg_run = 1'b0; cyc(5);
        expect_out(16'd10, 1'b0, "R2 run=0 hold");

        // R11 other mode holds
        cfg_mode = 3'b010; cfg_run = 1'b1; cyc(6);
        expect_out(16'd10, 1'b0, "R11 other mode hold");

        // R3/R4 ITR line 2 rising edges in external mode
        do_reset();
        cfg_mode = 3'b111; cfg_trig_sel = 3'b010; cfg_run = 1'b1;
        for (int i = 0; i < 3; i++) begin
            itr_in[2] = 1'b1; cyc(3); itr_in[2] = 1'b0; cyc(3);
        end
        expect_out(16'd3, 1'b1, "R3 R4 itr2 three edges");
        itr_in[1] = 1'b1; cyc(3); itr_in[1] = 1'b0; cyc(3);
        expect_out(16'd3, 1'b1, "R4 unselected itr1 ignored");

        // R9 flag clear
        clr_flag(); cyc(1);
        expect_out(16'd3, 1'b0, "R9 flag cleared");

        // R8 latency, filtered pin1 rising
        cfg_trig_sel = 3'b101;
        pin1 = 1'b1; cyc(3);
        expect_out(16'd3, 1'b0, "R8 no update after 3 edges");
        cyc(1);
        expect_out(16'd4, 1'b1, "R8 update after 4 edges");
        pin1 = 1'b0; cyc(8);
        expect_out(16'd4, 1'b1, "R5 falling ignored with pol=0");

        // R5 falling polarity
        cfg_pol1 = 1'b1; cyc(2);
        pin1 = 1'b1; cyc(8);
        expect_out(16'd4, 1'b1, "R5 rising ignored with pol=1");
        pin1 = 1'b0; cyc(8);
        expect_out(16'd5, 1'b1, "R5 falling counted with pol=1");
        cfg_pol1 = 1'b0;

        // R4 any-edge on pin1
        cyc(2);
        cfg_trig_sel = 3'b100;
        pin1 = 1'b1; cyc(8); pin1 = 1'b0; cyc(8);
        expect_out(16'd7, 1'b1, "R4 pin1 both edges");

        // R6 filter code 2
        cfg_trig_sel = 3'b101; cfg_filt1 = 4'd2; cyc(4);
        pin1 = 1'b1; cyc(3); pin1 = 1'b0; cyc(12);
        expect_out(16'd7, 1'b1, "R6 3-clock pulse dropped");
        pin1 = 1'b1; cyc(4); pin1 = 1'b0; cyc(14);
        expect_out(16'd8, 1'b1, "R6 4-clock pulse passes");
        cfg_filt1 = 4'd0;

        // R7 channel-2 mapping
        cfg_trig_sel = 3'b110; cfg_ch2_map = 2'b10; cyc(2);
        pin2 = 1'b1; cyc(8); pin2 = 1'b0; cyc(8);
        expect_out(16'd8, 1'b1, "R7 pin2 blocked map=10");
        cfg_ch2_map = 2'b01; cyc(2);
        pin2 = 1'b1; cyc(8); pin2 = 1'b0; cyc(8);
        expect_out(16'd9, 1'b1, "R7 pin2 routed map=01");

        // R3 run=0 blocks external counting, flag still sets (R9)
        clr_flag();
        cfg_run = 1'b0;
        pin2 = 1'b1; cyc(8); pin2 = 1'b0; cyc(8);
        expect_out(16'd9, 1'b1, "R3 R9 run=0 no count, flag set");

        // R9 set wins over clear
        cfg_run = 1'b1; clr_flag();
        cfg_trig_sel = 3'b001; cyc(1);
        itr_in[1] = 1'b1; flag_clr = 1'b1; cyc(1);
        flag_clr = 1'b0; itr_in[1] = 1'b0;
        expect_out(16'd10, 1'b1, "R9 set beats clear");

        // R4 code 111 gives no trigger
        clr_flag();
        cfg_trig_sel = 3'b111;
        itr_in = 4'hF; pin1 = 1'b1; pin2 = 1'b1; cyc(8);
        itr_in = 4'h0; pin1 = 1'b0; pin2 = 1'b0; cyc(8);
        expect_out(16'd10, 1'b0, "R4 code 111 no trigger");

        // R10 wrap
        do_reset();
        cfg_mode = 3'b000; cfg_run = 1'b1;
        cyc(65535);
        expect_out(16'hFFFF, 1'b0, "R10 reach max");
        cyc(1);
        expect_out(16'h0000, 1'b0, "R10 wrap to zero");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule